// File: doc/BRIEF.md
# Trace Memory Sequencer with Local Bus Acknowledge

This block holds one 16-bit control word that software writes and reads back whole. The word sets a trace address counter running over a fixed window of trace memory. When the counter reaches the last address of the window, it either restarts at the first address or stops and turns tracing off, depending on a loop bit in the word. The word also says which of six plug-in slots take part in tracing.

The same word carries a per-slot "absent" mask. Decoded bus strobes arrive once per slot. When a strobe targets the memory space of a slot that is marked absent, the block raises a data-transfer acknowledge itself, so that a bus cycle to an empty slot does not hang.

Top module: `trace_seq_top`

## Requirements
- R1: After reset the control word reads 0, the trace address equals the region start, trace is inactive and the acknowledge is low.
- R2: A register write stores all 16 bits on the next clock, and every bit reads back as written. This includes the spare bits 3..2, which have no function.
- R3: A write that sets bit 0 (trace enable) while it is 0 loads the region start into the trace address on the same clock.
- R4: Each trace strobe adds one to the address only while trace enable is 1. While trace enable is 0 a strobe leaves the address unchanged.
- R5: With bit 1 (loop) at 0, a strobe at the region end keeps the address at the region end and clears trace enable.
- R6: With loop at 1, a strobe at the region end sets the address to the region start and leaves trace enable at 1.
- R7: A register write in the same cycle as the end-of-region clear wins: the written word is stored as given.
- R8: Bits 15..10 mark slots 5..0 absent when 1. The acknowledge output is high one clock after any cycle in which a decoded strobe to an absent slot is present. It is low one clock after a cycle with no such strobe, so it falls one clock after the strobe drops. Strobes to slots that are present never raise it.
- R9: The trace slot output mirrors bits 9..4, with bit 9 for slot 5 and bit 4 for slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 16 | Control word write data |
| reg_rdata_o | output | 16 | Control word read data |
| trace_step_i | input | 1 | Trace advance strobe |
| slot_sel_i | input | 6 | Decoded bus strobe, one bit per slot |
| trace_addr_o | output | ADDR_W | Current trace address |
| trace_active_o | output | 1 | Trace enable state |
| trace_slots_o | output | 6 | Slots taking part in trace |
| ack_o | output | 1 | Local data-transfer acknowledge |

## Verification
The bench builds the block with an 8-bit address and a region from 0x10 to 0x14. With a window of only five addresses, both end-of-region paths can be reached in a few strobes: the stop with its hardware clear, and the wrap. So can the collision between a software write and the clear. Several absent masks combine with strobes to absent slots, strobes to present slots and strobes held for several cycles, which covers the rise and fall of the acknowledge.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;
  localparam int unsigned NUM_SLOTS = 6;
  localparam int unsigned CTRL_W    = 16;

  // bit order fixed: [15:10] absent, [9:4] trace slots, [3:2] spare, [1] loop, [0] enable
  typedef struct packed {
    logic [NUM_SLOTS-1:0] absent;
    logic [NUM_SLOTS-1:0] trace_slots;
    logic [1:0]           spare;
    logic                 loop_en;
    logic                 trace_en;
  } ctrl_t;
endpackage

// File: rtl/trace_ctrl_reg.sv
module trace_ctrl_reg
  import trace_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  ctrl_t wdata_i,
  input  logic  hw_clr_i,
  output ctrl_t q_o
);
  ctrl_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (we_i) begin
      q <= wdata_i;          // software beats hardware clear
    end else if (hw_clr_i) begin
      q.trace_en <= 1'b0;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/trace_addr_ctr.sv
module trace_addr_ctr #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] REGION_START = '0,
  parameter logic [ADDR_W-1:0] REGION_END   = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              en_i,
  input  logic              loop_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              stop_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              at_end, adv;

  assign at_end = (addr_q == REGION_END);
  assign adv    = en_i & step_i;
  assign stop_o = adv & at_end & ~loop_i;

  always_comb begin
    addr_d = addr_q;
    if (load_i) begin
      addr_d = REGION_START;
    end else if (adv) begin
      if (!at_end)     addr_d = addr_q + 1'b1;
      else if (loop_i) addr_d = REGION_START;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= REGION_START;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/slot_ack_gen.sv
module slot_ack_gen #(
  parameter int unsigned NUM = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] sel_i,
  input  logic [NUM-1:0] absent_i,
  output logic           ack_o
);
  logic [NUM-1:0] hit_q;

  for (genvar s = 0; s < NUM; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hit_q[s] <= 1'b0;
      else         hit_q[s] <= sel_i[s] & absent_i[s];
    end
  end

  assign ack_o = |hit_q;
endmodule

// File: rtl/trace_seq_top.sv
module trace_seq_top
  import trace_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REGION_START = '0,
  parameter logic [ADDR_W-1:0] REGION_END   = 16'h0FFF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [CTRL_W-1:0]    reg_wdata_i,
  output logic [CTRL_W-1:0]    reg_rdata_o,
  input  logic                 trace_step_i,
  input  logic [NUM_SLOTS-1:0] slot_sel_i,
  output logic [ADDR_W-1:0]    trace_addr_o,
  output logic                 trace_active_o,
  output logic [NUM_SLOTS-1:0] trace_slots_o,
  output logic                 ack_o
);
  ctrl_t ctrl_q, wdata;
  logic  stop, load;

  assign wdata = ctrl_t'(reg_wdata_i);
  assign load  = reg_we_i & wdata.trace_en & ~ctrl_q.trace_en;

  trace_ctrl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (wdata),
    .hw_clr_i(stop),
    .q_o     (ctrl_q)
  );

  trace_addr_ctr #(
    .ADDR_W      (ADDR_W),
    .REGION_START(REGION_START),
    .REGION_END  (REGION_END)
  ) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(trace_step_i),
    .en_i  (ctrl_q.trace_en),
    .loop_i(ctrl_q.loop_en),
    .addr_o(trace_addr_o),
    .stop_o(stop)
  );

  slot_ack_gen #(.NUM(NUM_SLOTS)) u_ack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (slot_sel_i),
    .absent_i(ctrl_q.absent),
    .ack_o   (ack_o)
  );

  assign reg_rdata_o    = ctrl_q;
  assign trace_active_o = ctrl_q.trace_en;
  assign trace_slots_o  = ctrl_q.trace_slots;
endmodule

// File: rtl/trace_seq_chk.sv
module trace_seq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REGION_START = '0,
  parameter logic [ADDR_W-1:0] REGION_END   = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              wen_bit_i,
  input logic              step_i,
  input logic [5:0]        sel_i,
  input logic [5:0]        absent_i,
  input logic              loop_i,
  input logic              en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ack_i
);
  AST_ADDR_IN_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i >= REGION_START && addr_i <= REGION_END); // R3

  AST_LOAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wen_bit_i && !en_i |=> en_i && addr_i == REGION_START); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !we_i |=> $stable(addr_i)); // R4

  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !loop_i && step_i && !we_i && addr_i == REGION_END
    |=> !en_i && addr_i == REGION_END); // R5

  AST_WRAP_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && loop_i && step_i && !we_i && addr_i == REGION_END
    |=> en_i && addr_i == REGION_START); // R6

  AST_ACK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(sel_i & absent_i) |=> ack_i); // R8

  AST_ACK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(sel_i & absent_i)) |=> !ack_i); // R8
endmodule

bind trace_seq_top trace_seq_chk #(
  .ADDR_W      (ADDR_W),
  .REGION_START(REGION_START),
  .REGION_END  (REGION_END)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (reg_we_i),
  .wen_bit_i(reg_wdata_i[0]),
  .step_i   (trace_step_i),
  .sel_i    (slot_sel_i),
  .absent_i (reg_rdata_o[15:10]),
  .loop_i   (reg_rdata_o[1]),
  .en_i     (reg_rdata_o[0]),
  .addr_i   (trace_addr_o),
  .ack_i    (ack_o)
);

// File: tb/sim_trace_seq_top.sv
`timescale 1ns/1ps
module sim_trace_seq_top;
  localparam int unsigned AW = 8;
  localparam logic [AW-1:0] RS = 8'h10;
  localparam logic [AW-1:0] RE = 8'h14;

  logic          clk = 0, rst_n = 0;
  logic          we = 0, step = 0;
  logic [15:0]   wdata = '0;
  logic [5:0]    sel = '0;
  logic [15:0]   rdata;
  logic [AW-1:0] addr;
  logic          active, ack;
  logic [5:0]    slots;

  always #4 clk = ~clk;

  trace_seq_top #(.ADDR_W(AW), .REGION_START(RS), .REGION_END(RE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .trace_step_i(step), .slot_sel_i(sel),
    .trace_addr_o(addr), .trace_active_o(active), .trace_slots_o(slots),
    .ack_o(ack));

  typedef struct {
    logic [15:0]   r;
    logic [AW-1:0] a;
    logic          k;
    string         tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  logic [15:0]   m_reg = '0;
  logic [AW-1:0] m_addr = RS;
  logic          m_ack = 0;

  task automatic expect_now(string tag);
    item_t it;
    it.r = m_reg; it.a = m_addr; it.k = m_ack; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cyc(input logic w, input logic [15:0] d, input logic s,
                     input logic [5:0] sl, input string tag);
    logic [15:0]   n_reg;
    logic [AW-1:0] n_addr;
    logic          stop;
    @(negedge clk);
    we = w; wdata = d; step = s; sel = sl;
    stop   = m_reg[0] && s && (m_addr == RE) && !m_reg[1];
    n_addr = m_addr;
    if (w && d[0] && !m_reg[0])     n_addr = RS;
    else if (m_reg[0] && s) begin
      if (m_addr != RE)             n_addr = m_addr + 1'b1;
      else if (m_reg[1])            n_addr = RS;
    end
    n_reg = w ? d : (stop ? (m_reg & 16'hFFFE) : m_reg);
    m_ack = |(sl & m_reg[15:10]);
    m_reg = n_reg; m_addr = n_addr;
    @(posedge clk); #1;
    expect_now(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        total++;
        if (rdata !== it.r || addr !== it.a || ack !== it.k ||
            active !== it.r[0] || slots !== it.r[9:4]) begin
          bad++;
          $display("FAIL %s: rdata=%h addr=%h ack=%b act=%b slots=%b exp rdata=%h addr=%h ack=%b",
                   it.tag, rdata, addr, ack, active, slots, it.r, it.a, it.k);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 expect_now("R1 reset state");
    @(negedge clk); rst_n = 1;
    cyc(0, 16'h0, 0, 6'h0, "R1 idle after reset");
    // R2 / R9 round trip incl. spare bits
    cyc(1, 16'h000C, 0, 6'h0, "R2 spare bits");
    cyc(1, 16'h5A5C, 0, 6'h0, "R2 full word");
    cyc(1, 16'h03F0, 0, 6'h0, "R9 trace slots all");
    cyc(1, 16'h0150, 0, 6'h0, "R9 trace slots mix");
    // R4 step ignored while disabled
    cyc(0, 16'h0, 1, 6'h0, "R4 step while off");
    cyc(0, 16'h0, 1, 6'h0, "R4 step while off 2");
    // R3 enable, no loop
    cyc(1, 16'h0001, 0, 6'h0, "R3 enable loads start");
    for (int i = 0; i < 4; i++) cyc(0, 16'h0, 1, 6'h0, "R4 advance");
    cyc(0, 16'h0, 0, 6'h0, "R4 no strobe holds");
    cyc(0, 16'h0, 1, 6'h0, "R5 stop at end");
    cyc(0, 16'h0, 1, 6'h0, "R5 stays stopped");
    // R6 loop
    cyc(1, 16'h0003, 0, 6'h0, "R3 re-enable with loop");
    for (int i = 0; i < 4; i++) cyc(0, 16'h0, 1, 6'h0, "R6 advance");
    cyc(0, 16'h0, 1, 6'h0, "R6 wrap keeps enable");
    cyc(0, 16'h0, 1, 6'h0, "R6 after wrap");
    // R7 write vs hardware clear
    cyc(1, 16'h0001, 0, 6'h0, "R7 loop off, no reload");
    for (int i = 0; i < 3; i++) cyc(0, 16'h0, 1, 6'h0, "R7 walk to end");
    cyc(1, 16'h0001, 1, 6'h0, "R7 write wins over clear");
    cyc(1, 16'h0000, 0, 6'h0, "R7 disable");
    // R8 acknowledge
    cyc(1, 16'h2800, 0, 6'h08, "R8 mask load, no ack yet");
    cyc(0, 16'h0, 0, 6'h08, "R8 absent slot3 ack");
    cyc(0, 16'h0, 0, 6'h08, "R8 held strobe keeps ack");
    cyc(0, 16'h0, 0, 6'h00, "R8 ack falls");
    cyc(0, 16'h0, 0, 6'h04, "R8 present slot2 no ack");
    cyc(0, 16'h0, 0, 6'h02, "R8 absent slot1 ack");
    cyc(0, 16'h0, 0, 6'h3F, "R8 all strobes");
    cyc(1, 16'hFC00, 0, 6'h01, "R8 all absent");
    cyc(0, 16'h0, 0, 6'h20, "R8 slot5 absent ack");
    cyc(0, 16'h0, 0, 6'h00, "R8 quiet");
    cyc(0, 16'h0, 0, 6'h00, "R8 quiet 2");
    @(negedge clk); we = 0; step = 0; sel = 0;
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule